// File: doc/BRIEF.md
# Four-Phase Data-Select Sequencer

This block drives four data-select strobes, each with a complementary output, that take turns routing one of four sensor outputs onto a single converter input. Both parts of the block run on the 20 MHz sample clock. A 4-bit dwell timer decides how long each strobe stays high. A 4-bit one-hot shift register passes a single high bit from one strobe to the next.

The timer starts at 7. It counts up while the sync input is high, wraps through 15 and arrives at 0 nine clocks later. While it sits at 0, the step output is high. On the following edge the shift register moves its high bit one place toward strobe 0, a low enters at strobe 3, and the timer starts again from 7. Each strobe is therefore high for ten clocks, which is 500 ns. One full pass over the four strobes lasts forty clocks, or 2 us.

The surrounding logic pulls sync low for one clock at the end of each pixel cycle. On the next rising edge the timer loads 7 and the shift register loads 1000. This realigns the sequence to the start of the new pixel cycle, whatever state the block was in.

Top module: `dsel_sequencer`

## Requirements
- R1: After the asynchronous active-low reset is released, sel_o is 1000 (bit 3 high) and step_o is low.
- R2: With sync_i held high after a reload, sel_o[3] stays high for exactly 10 clocks. Then sel_o[2] is high for 10 clocks, then sel_o[1] for 10 clocks, then sel_o[0] for 10 clocks.
- R3: While sync_i is high, every edge on which step_o is high shifts sel_o right by one place (bit i takes bit i+1) and loads a 0 into bit 3.
- R4: Once four shifts have followed a reload and sync_i is still high, sel_o stays 0000 until the next reload. The timer keeps running, so step_o still pulses once every 10 clocks.
- R5: A clock edge that samples sync_i low loads sel_o with 1000 and starts a new 10-clock dwell. This happens in any state, including the middle of a dwell.
- R6: At every clock, no more than one bit of sel_o is high.
- R7: sel_n_o is always the bitwise complement of sel_o.
- R8: step_o is high on the 10th clock of each dwell, that is, 9 clocks after a reload or a shift. While sync_i is high, sel_o changes only on an edge at which step_o was high.
- R9: For as long as sync_i is held low, sel_o stays 1000 and step_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Pixel-cycle alignment; low for one clock requests a reload |
| sel_o | output | 4 | One-hot data-select strobes; bit 3 is the first phase |
| sel_n_o | output | 4 | Complement of sel_o |
| step_o | output | 1 | High in the last clock of each dwell |

## Verification
A wrong timer value shows up at the ports as a strobe that is longer or shorter than 10 clocks, or as a step_o pulse in the wrong place. The error appears within one dwell, at most ten clocks after the fault. A corrupted shift register shows up on the very next clock as either more than one high select or a high bit in the wrong position. A missed reload shows up on the edge right after sync_i goes low, because sel_o then differs from 1000.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

  // Operation applied to the timer and shifter on the next clock edge
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_STEP   = 2'd1,
    OP_RELOAD = 2'd2
  } dsel_op_e;

  // Clocks spent by the timer going from its start value to its terminal value 0
  function automatic int unsigned dwell_clocks(input int unsigned cnt_w,
                                               input int unsigned start_val);
    return (1 << cnt_w) - start_val + 1;
  endfunction

endpackage

// File: rtl/dsel_ctrl.sv
module dsel_ctrl
  import dsel_pkg::*;
(
  input  logic     sync_i,
  input  logic     term_i,
  output dsel_op_e op_o
);

  // Sync low has priority over everything; otherwise the terminal count steps
  always_comb begin
    if (!sync_i)     op_o = OP_RELOAD;
    else if (term_i) op_o = OP_STEP;
    else             op_o = OP_HOLD;
  end

endmodule

// File: rtl/dsel_timer.sv
module dsel_timer
  import dsel_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned START_VAL = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  dsel_op_e op_i,
  output logic     term_o
);

  localparam logic [CNT_W-1:0] START = CNT_W'(START_VAL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    unique case (op_i)
      OP_RELOAD: cnt_d = START;
      OP_STEP:   cnt_d = START;
      default:   cnt_d = cnt_q + CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= START;
    else        cnt_q <= cnt_d;
  end

  assign term_o = (cnt_q == '0);

endmodule

// File: rtl/dsel_shifter.sv
module dsel_shifter
  import dsel_pkg::*;
#(
  parameter int unsigned NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dsel_op_e           op_i,
  output logic [NUM_SEL-1:0] q_o
);

  localparam int unsigned TOP = NUM_SEL - 1;

  logic [NUM_SEL-1:0] q_q;
  logic [NUM_SEL-1:0] q_d;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_stage
    // Value a parallel load puts into this stage: only the top stage is set
    localparam logic LOAD_BIT = (i == TOP);
    logic from_up;
    if (i == TOP) begin : g_top
      assign from_up = 1'b0;
    end else begin : g_mid
      assign from_up = q_q[i+1];
    end

    always_comb begin
      unique case (op_i)
        OP_RELOAD: q_d[i] = LOAD_BIT;
        OP_STEP:   q_d[i] = from_up;
        default:   q_d[i] = q_q[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q[i] <= LOAD_BIT;
      else        q_q[i] <= q_d[i];
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/dsel_sequencer.sv
module dsel_sequencer
  import dsel_pkg::*;
#(
  parameter int unsigned NUM_SEL   = 4,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned START_VAL = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_i,
  output logic [NUM_SEL-1:0] sel_o,
  output logic [NUM_SEL-1:0] sel_n_o,
  output logic               step_o
);

  localparam int unsigned DWELL = dwell_clocks(CNT_W, START_VAL);

  dsel_op_e           op;
  logic               term;
  logic [NUM_SEL-1:0] sel_q;

  dsel_ctrl u_ctrl (
    .sync_i (sync_i),
    .term_i (term),
    .op_o   (op)
  );

  dsel_timer #(
    .CNT_W     (CNT_W),
    .START_VAL (START_VAL)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op),
    .term_o (term)
  );

  dsel_shifter #(
    .NUM_SEL (NUM_SEL)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op),
    .q_o   (sel_q)
  );

  // Each strobe gets its own true and complemented driver
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_out
    assign sel_o[i]   = sel_q[i];
    assign sel_n_o[i] = ~sel_q[i];
  end

  assign step_o = term;

  initial begin
    if (DWELL < 2) $error("dwell too short");
  end

endmodule

// File: rtl/dsel_sequencer_chk.sv
module dsel_sequencer_chk #(
  parameter int unsigned NUM_SEL = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_i,
  input logic [NUM_SEL-1:0] sel_o,
  input logic               step_o
);

  localparam logic [NUM_SEL-1:0] FIRST = {1'b1, {(NUM_SEL-1){1'b0}}};

  assert_one_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> sel_o == FIRST);

  assert_no_step_low_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> !step_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !step_o) |=> $stable(sel_o));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && step_o) |=> sel_o == ($past(sel_o) >> 1));

endmodule

bind dsel_sequencer dsel_sequencer_chk #(.NUM_SEL(NUM_SEL)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sync_i (sync_i),
  .sel_o  (sel_o),
  .step_o (step_o)
);

// File: tb/sim_dsel_sequencer.sv
module sim_dsel_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_i = 1'b1;
  logic [3:0] sel_o;
  logic [3:0] sel_n_o;
  logic       step_o;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  int unsigned k = 0;       // clocks since last reload (model state)
  string       cur_req = "R1";
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dsel_sequencer u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .sel_o   (sel_o),
    .sel_n_o (sel_n_o),
    .step_o  (step_o)
  );

  // Requirement-level model: the strobe index follows from clocks since reload
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       k <= 0;
    else if (!sync_i) k <= 0;
    else              k <= k + 1;
  end

  function automatic logic [3:0] exp_sel(input int unsigned kk);
    if (kk >= 40) return 4'b0000;      // R4
    return 4'b1000 >> (kk / 10);       // R2
  endfunction

  function automatic logic exp_step(input int unsigned kk);
    return (kk % 10) == 9;              // R8
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  // Sample at the falling edge, then drive the next sync value
  task automatic tick(input logic next_sync);
    @(negedge clk);
    check(cur_req, sel_o, exp_sel(k));
    check("R7", sel_n_o, ~exp_sel(k));
    check("R8", {3'b0, step_o}, {3'b0, exp_step(k)});
    check("R6", {3'b0, ($countones(sel_o) <= 1)}, 4'b0001);
    sync_i = next_sync;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", sel_o, 4'b1000);
    check("R1", {3'b0, step_o}, 4'b0000);
    rst_n = 1'b1;

    // Aligned pixel cycles: sync low on the 40th clock (R2, R3)
    cur_req = "R2";
    for (int c = 0; c < 4; c++) begin
      for (int j = 0; j < 40; j++) tick(j == 38 ? 1'b0 : 1'b1);
    end

    // Sync stays high past the pass: all selects low (R4)
    cur_req = "R4";
    for (int j = 0; j < 75; j++) tick(1'b1);
    tick(1'b0);

    // Sync held low for a while (R9)
    cur_req = "R9";
    for (int j = 0; j < 12; j++) tick(1'b0);
    for (int j = 0; j < 15; j++) tick(1'b1);

    // Reload in the middle of a dwell (R5)
    cur_req = "R5";
    for (int j = 0; j < 4; j++) tick(1'b1);
    tick(1'b0);
    for (int j = 0; j < 23; j++) tick(1'b1);
    tick(1'b0);
    for (int j = 0; j < 9; j++) tick(1'b1);

    // Random sync traffic (R3)
    cur_req = "R3";
    for (int j = 0; j < 3000; j++) tick(($urandom % 37) != 0);
    for (int j = 0; j < 50; j++) tick(1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog k=%0d actual=hung expected=done", k);
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule